// File: doc/BRIEF.md
# Bit-Test Conditional Skip Unit

This unit executes the two conditional-skip instructions of a small 8-bit controller core. One variant skips the following instruction when a selected bit of a data register is clear; the other skips it when that bit is set. Each instruction cycle has four clock phases. In phase 0 the unit captures the word now executing, the word already prefetched behind it, and the bank-select value. In phase 1 it issues one read to the register file. In phase 2 it tests the returned bit. At the end of phase 3 it decides whether the prefetched work must be squashed.

The register address is 12 bits. A bank flag in the word picks the source of the upper four bits. When the flag is set, they come from the bank-select register. When it is clear, a fixed access window applies: low file addresses map to bank 0 and high ones to the special-register bank. When a skip is taken, the unit raises a flush for one whole instruction cycle. If the prefetched word opens a two-word instruction, the flush lasts two cycles so that the trailing word is also discarded. Two-word openers are recognised by a configurable set of mask/match prefixes.

Top module: `btsk_unit`

## Requirements
- R1: `phase_o` is 0 while reset is asserted. After reset it advances by one on every clock and wraps from 3 to 0.
- R2: The word on `instr_i` is sampled at the clock edge that ends phase 0. Bits [15:12] are the opcode, bits [11:9] the bit index, bit 8 the bank flag and bits [7:0] the file address. Only opcodes 4'b1011 and 4'b1010 execute; any other opcode issues no register read.
- R3: An executing bit-test asserts `rf_rd_en_o` during phase 1 of its cycle and in no other phase.
- R4: With bank flag 0, the read address is {4'h0, f} for f below 8'h80 and {4'hF, f} otherwise, whatever the value of `bsr_i`.
- R5: With bank flag 1, the read address is {bsr_i, f}, using the `bsr_i` value sampled in phase 0.
- R6: The tested bit is bit [11:9] of the word of the data returned on `rf_rd_data_i` in phase 2; every index 0 to 7 selects the matching data bit.
- R7: Opcode 4'b1011 skips when the tested bit is 0, and opcode 4'b1010 skips when it is 1. A bit-test that does not skip leaves `flush_o` low in the next instruction cycle.
- R8: A taken skip whose prefetched word is one word long holds `flush_o` high for exactly the four phases of the next instruction cycle.
- R9: A taken skip whose prefetched word matches a two-word prefix holds `flush_o` high for exactly the next two instruction cycles (eight clocks). With the default prefixes, 4'b1100 in bits [15:12] or 7'b1110110 in bits [15:9] marks a two-word opener.
- R10: While `flush_o` is high, the unit ignores `instr_i`, including bit-test opcodes: no read is issued and no further skip is started.
- R11: Reset clears any pending or ongoing flush. `flush_o` and `rf_rd_en_o` are low while reset is asserted and after its release, until a new skip is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| instr_i | input | 16 | Instruction word in execution, sampled in phase 0 |
| next_instr_i | input | 16 | Prefetched word that follows, sampled in phase 0 |
| bsr_i | input | 4 | Bank-select register value |
| rf_rd_en_o | output | 1 | Register-file read request |
| rf_rd_addr_o | output | 12 | Register-file read address |
| rf_rd_data_i | input | 8 | Read data, valid one clock after the request |
| flush_o | output | 1 | Squash the current instruction cycle (execute as no-operation) |
| phase_o | output | 2 | Phase within the instruction cycle |

## Verification
The bench builds the unit with its default parameters: a 4-bit bank select, an access split at 8'h80 with the special bank at 4'hF, and two two-word prefixes. These defaults let the bench reach both access-window halves, banked addressing, and skips over a one-word word, over a word matching each prefix, and over a near-miss word that matches neither. A behavioural reference model predicts the phase, read request, address and flush on every clock. It runs sweeps of all eight bit indices for both opcodes, places bit-test words inside flushed cycles, and asserts reset in the middle of a two-cycle flush.

// File: rtl/btsk_pkg.sv
package btsk_pkg;
  localparam int IW = 16;
  localparam int DW = 8;
  localparam int FW = 8;
  localparam int BIW = 3;

  localparam logic [3:0] OPC_SKIP_IF_CLR = 4'b1011;
  localparam logic [3:0] OPC_SKIP_IF_SET = 4'b1010;

  typedef struct packed {
    logic           live;
    logic           on_set;
    logic [BIW-1:0] bidx;
    logic           banked;
    logic [FW-1:0]  file;
  } bt_op_t;

  function automatic bt_op_t unpack_op(input logic [IW-1:0] w, input logic allow);
    bt_op_t o;
    o.live   = allow && ((w[15:12] == OPC_SKIP_IF_CLR) || (w[15:12] == OPC_SKIP_IF_SET));
    o.on_set = (w[15:12] == OPC_SKIP_IF_SET);
    o.bidx   = w[11:9];
    o.banked = w[8];
    o.file   = w[7:0];
    return o;
  endfunction
endpackage

// File: rtl/btsk_phase.sv
module btsk_phase #(
  parameter int PHASES = 4,
  localparam int PW = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] phase,
  output logic          at_last
);
  logic [PW-1:0] phase_d;

  assign at_last = (phase == PW'(PHASES - 1));

  always_comb begin
    phase_d = at_last ? '0 : phase + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase_d;
  end
endmodule

// File: rtl/btsk_decode.sv
module btsk_decode
  import btsk_pkg::*;
#(
  parameter int              BSR_W     = 4,
  parameter logic [FW-1:0]   ACC_SPLIT = 8'h80,
  parameter logic [BSR_W-1:0] SFR_BANK = '1,
  parameter logic [BSR_W-1:0] LOW_BANK = '0,
  localparam int AW = BSR_W + FW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             allow,
  input  logic             read_slot,
  input  logic [IW-1:0]    instr,
  input  logic [IW-1:0]    next_instr,
  input  logic [BSR_W-1:0] bsr,
  output bt_op_t           op_q,
  output logic [IW-1:0]    next_q,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr
);
  bt_op_t           op_d;
  logic [IW-1:0]    next_d;
  logic [BSR_W-1:0] bsr_q, bsr_d;

  always_comb begin
    op_d   = op_q;
    next_d = next_q;
    bsr_d  = bsr_q;
    if (load_en) begin
      op_d   = unpack_op(instr, allow);
      next_d = next_instr;
      bsr_d  = bsr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      next_q <= '0;
      bsr_q  <= '0;
    end else begin
      op_q   <= op_d;
      next_q <= next_d;
      bsr_q  <= bsr_d;
    end
  end

  always_comb begin
    rd_en = read_slot && op_q.live;
    if (op_q.banked)                rd_addr = {bsr_q, op_q.file};
    else if (op_q.file >= ACC_SPLIT) rd_addr = {SFR_BANK, op_q.file};
    else                            rd_addr = {LOW_BANK, op_q.file};
  end
endmodule

// File: rtl/btsk_squash.sv
module btsk_squash
  import btsk_pkg::*;
#(
  parameter int NPFX = 2,
  parameter logic [NPFX-1:0][IW-1:0] PFX_MASK  = {16'hFE00, 16'hF000},
  parameter logic [NPFX-1:0][IW-1:0] PFX_MATCH = {16'hEC00, 16'hC000},
  localparam int CNT_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          test_slot,
  input  logic          end_slot,
  input  bt_op_t        op,
  input  logic [IW-1:0] next_word,
  input  logic [DW-1:0] rd_data,
  output logic          flush
);
  logic [NPFX-1:0]  pfx_hit;
  logic             two_word;
  logic             skip_q, skip_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  for (genvar i = 0; i < NPFX; i++) begin : g_pfx
    assign pfx_hit[i] = ((next_word & PFX_MASK[i]) == PFX_MATCH[i]);
  end
  assign two_word = |pfx_hit;
  assign flush    = (cnt_q != '0);

  always_comb begin
    skip_d = skip_q;
    cnt_d  = cnt_q;
    if (test_slot)
      skip_d = op.live && (rd_data[op.bidx] == op.on_set);
    if (end_slot) begin
      skip_d = 1'b0;
      if (cnt_q != '0)  cnt_d = cnt_q - CNT_W'(1);
      else if (skip_q)  cnt_d = two_word ? CNT_W'(2) : CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      skip_q <= skip_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/btsk_unit.sv
module btsk_unit
  import btsk_pkg::*;
#(
  parameter int               BSR_W     = 4,
  parameter logic [7:0]       ACC_SPLIT = 8'h80,
  parameter logic [BSR_W-1:0] SFR_BANK  = '1,
  parameter int               NPFX      = 2,
  parameter logic [NPFX-1:0][15:0] PFX_MASK  = {16'hFE00, 16'hF000},
  parameter logic [NPFX-1:0][15:0] PFX_MATCH = {16'hEC00, 16'hC000},
  localparam int AW = BSR_W + 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      instr_i,
  input  logic [15:0]      next_instr_i,
  input  logic [BSR_W-1:0] bsr_i,
  output logic             rf_rd_en_o,
  output logic [AW-1:0]    rf_rd_addr_o,
  input  logic [7:0]       rf_rd_data_i,
  output logic             flush_o,
  output logic [1:0]       phase_o
);
  localparam int PHASES = 4;

  logic          at_last;
  bt_op_t        op_q;
  logic [IW-1:0] next_q;

  btsk_phase #(.PHASES(PHASES)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase   (phase_o),
    .at_last (at_last)
  );

  btsk_decode #(
    .BSR_W     (BSR_W),
    .ACC_SPLIT (ACC_SPLIT),
    .SFR_BANK  (SFR_BANK),
    .LOW_BANK  ('0)
  ) u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (phase_o == 2'd0),
    .allow      (!flush_o),
    .read_slot  (phase_o == 2'd1),
    .instr      (instr_i),
    .next_instr (next_instr_i),
    .bsr        (bsr_i),
    .op_q       (op_q),
    .next_q     (next_q),
    .rd_en      (rf_rd_en_o),
    .rd_addr    (rf_rd_addr_o)
  );

  btsk_squash #(
    .NPFX      (NPFX),
    .PFX_MASK  (PFX_MASK),
    .PFX_MATCH (PFX_MATCH)
  ) u_squash (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_slot (phase_o == 2'd2),
    .end_slot  (at_last),
    .op        (op_q),
    .next_word (next_q),
    .rd_data   (rf_rd_data_i),
    .flush     (flush_o)
  );
endmodule

// File: rtl/btsk_chk.sv
module btsk_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rf_rd_en_o,
  input logic       flush_o,
  input logic [1:0] phase_o
);
  logic [3:0] flush_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flush_run <= '0;
    else if (flush_o) flush_run <= flush_run + 4'd1;
    else              flush_run <= '0;
  end

  p_phase_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd3) |=> (phase_o == 2'd0));

  p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != 2'd3) |=> (phase_o == $past(phase_o) + 2'd1));

  p_read_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd_en_o |-> (phase_o == 2'd1));

  p_no_read_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> !rf_rd_en_o);

  p_flush_whole_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != 2'd0) |-> $stable(flush_o));

  p_flush_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_run <= 4'd8);
endmodule

bind btsk_unit btsk_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rf_rd_en_o (rf_rd_en_o),
  .flush_o    (flush_o),
  .phase_o    (phase_o)
);

// File: tb/sim_btsk_unit.sv
module sim_btsk_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] nxt = '0;
  logic [3:0]  bsr = '0;
  logic        rd_en;
  logic [11:0] rd_addr;
  logic [7:0]  rd_data = '0;
  logic        flush;
  logic [1:0]  phase;
  logic [7:0]  rf_value = '0;

  int errors = 0;
  int checks = 0;
  int ref_flush = 0;
  bit ref_two = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) if (rd_en) rd_data <= rf_value;

  btsk_unit u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_i      (instr),
    .next_instr_i (nxt),
    .bsr_i        (bsr),
    .rf_rd_en_o   (rd_en),
    .rf_rd_addr_o (rd_addr),
    .rf_rd_data_i (rd_data),
    .flush_o      (flush),
    .phase_o      (phase)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit is_two(input logic [15:0] w);
    return (w[15:12] == 4'b1100) || (w[15:9] == 7'b1110110);
  endfunction

  task automatic do_cycle(input logic [15:0] w, input logic [15:0] n,
                          input logic [3:0] b, input logic [7:0] v);
    bit flushing, exec, skip;
    int exp_addr;
    string ftag;
    instr = w; nxt = n; bsr = b; rf_value = v;
    flushing = (ref_flush > 0);
    exec = !flushing && (w[15:12] == 4'b1011 || w[15:12] == 4'b1010);
    skip = exec && (v[w[11:9]] == (w[15:12] == 4'b1010));
    if (w[8])             exp_addr = {b, w[7:0]};
    else if (w[7:0] >= 8'h80) exp_addr = {4'hF, w[7:0]};
    else                  exp_addr = {4'h0, w[7:0]};
    ftag = flushing ? (ref_two ? "R9" : "R8") : "R7";
    for (int p = 0; p < 4; p++) begin
      chk(phase == 2'(p), "R1", phase, p);
      chk(flush == flushing, ftag, flush, flushing);
      chk(rd_en == (exec && p == 1), flushing ? "R10" : (exec ? "R3" : "R2"), rd_en, exec && p == 1);
      if (exec && p == 1)
        chk(rd_addr == 12'(exp_addr), w[8] ? "R5" : "R4", rd_addr, exp_addr);
      @(posedge clk);
      @(negedge clk);
    end
    if (flushing) ref_flush--;
    else if (skip) begin
      ref_two = is_two(n);
      ref_flush = ref_two ? 2 : 1;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bsr = 4'h3;
    repeat (3) @(negedge clk);
    chk(phase == 2'd0, "R1", phase, 0);
    chk(flush == 1'b0, "R11", flush, 0);
    chk(rd_en == 1'b0, "R11", rd_en, 0);
    rst_n = 1'b1;

    do_cycle(16'h0000, 16'h0000, 4'h0, 8'h00);
    // R7: skip-if-clear, bit 3 set -> no skip; R4 low access half
    do_cycle(16'hB625, 16'h0F00, 4'h9, 8'h08);
    do_cycle(16'h0F00, 16'h0000, 4'h0, 8'h00);
    // R7/R8: bit 3 clear -> skip one word; R10: bit-test inside flush ignored
    do_cycle(16'hB625, 16'h0F00, 4'h9, 8'hF7);
    do_cycle(16'hA1FF, 16'h0000, 4'h2, 8'hFF);
    // R5/R9: skip-if-set banked, over 1100 opener
    do_cycle(16'hAF9A, 16'hC123, 4'h5, 8'h80);
    do_cycle(16'hB000, 16'h0000, 4'h1, 8'h00);
    do_cycle(16'hA100, 16'h0000, 4'h1, 8'hFF);
    // R7: skip-if-set bit 0 clear -> no skip
    do_cycle(16'hA010, 16'h0000, 4'h0, 8'hFE);
    // R4: high access half, bsr ignored; skip over 1110110 opener (R9)
    do_cycle(16'hA0C4, 16'hED00, 4'h7, 8'h01);
    do_cycle(16'h0000, 16'h0000, 4'h0, 8'h00);
    do_cycle(16'h0000, 16'h0000, 4'h0, 8'h00);
    // near-miss prefix: one-cycle flush (R8)
    do_cycle(16'hB010, 16'hEE00, 4'h0, 8'h00);
    do_cycle(16'h0000, 16'h0000, 4'h0, 8'h00);
    // R2: other opcodes issue no read
    do_cycle(16'h9725, 16'hC000, 4'h3, 8'hFF);
    do_cycle(16'hBFFF & 16'h7FFF, 16'h0000, 4'h3, 8'h00);
    // R6: sweep every bit index for both opcodes
    for (int i = 0; i < 8; i++) begin
      do_cycle({4'b1011, 3'(i), 1'b1, 8'(16 * i)}, 16'h0000, 4'(i), 8'(1 << i));
      do_cycle({4'b1010, 3'(i), 1'b0, 8'(20 * i)}, 16'h0000, 4'h0, 8'(1 << i));
      do_cycle(16'h0000, 16'h0000, 4'h0, 8'h00);
      do_cycle({4'b1010, 3'(i), 1'b0, 8'h11}, 16'h0000, 4'h0, ~8'(1 << i));
    end
    // R11: reset in the middle of a two-cycle flush
    do_cycle(16'hA000, 16'hC000, 4'h0, 8'h01);
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(flush == 1'b0, "R11", flush, 0);
    chk(phase == 2'd0, "R11", phase, 0);
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    ref_flush = 0;
    do_cycle(16'h0000, 16'h0000, 4'h0, 8'h00);
    do_cycle(16'hB000, 16'h0000, 4'h0, 8'h01);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule